// File: doc/BRIEF.md
# Parallel Maximal-Length Sequence Generator

This block is a linear feedback shift register that emits a maximal-length pseudo-random bit stream. On every enabled clock it advances a parameterised number of bit positions at once and presents the bits produced in that step as one registered parallel word. The current register contents are also available on their own output, so other logic can read them or compare a later state against them. A load port writes a seed into the register.

Parameters choose the register length, the two feedback tap stages, the number of bits per step, where the first bit of a step lands in the output word, and whether the feedback is an XOR or an XNOR of the taps. The defaults give a 23-stage register with taps at stages 23 and 18, eight bits per step, XNOR feedback and the first bit in word bit 0. The block can drive wide pattern generators or scramblers that need one word of the stream per cycle. A seed that would lock the register is replaced with a safe value.

Top module: `prbs_par_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next state equals the lock-up value with bit 0 inverted (all ones except bit 0 for XNOR feedback, and only bit 0 set for XOR feedback). The output word becomes zero.
- R2: When `load` is high, the next state is taken from `seed` whatever `en` is, and `dout` keeps its value.
- R3: A seed equal to the lock-up value (all ones for XNOR, all zeros for XOR) loads the reset value of R1 instead.
- R4: One serial step makes a new bit equal to state bit TAP_A-1 XOR state bit TAP_B-1, inverted when INVERT=1. It then shifts the state one place toward the MSB and puts the new bit into bit 0. An enabled step with `load` low applies this STEP times.
- R5: With REVERSE=0, the k-th bit produced in a step (k=0 first) lands at `dout[k]`. With REVERSE=1 it lands at `dout[STEP-1-k]`. The word updates at the same clock edge as the state.
- R6: With `en` and `load` both low, `state` and `dout` hold their values.
- R7: With single-bit steps, the state first returns to a loaded seed after exactly 2^LEN-1 enabled steps.
- R8: After reset, the state never equals the lock-up value.
- R9: INVERT selects XNOR feedback (1) or XOR feedback (0). Both settings give maximal-length sequences.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance STEP bit positions |
| load | input | 1 | Load seed (has priority over en) |
| seed | input | LEN | Seed value |
| dout | output | STEP | Registered bits of the last step |
| state | output | LEN | Current register contents |

## Verification
On every cycle the assertions check several things. After reset the register is never in the lock-up state. A load and an idle cycle each behave as specified. An enabled step moves the old contents up by STEP places, and the output word agrees with the newly produced low state bits in the selected order. Only the bench's scenarios can show the others. The exact feedback values for both polarities are compared against a serial model under random enable and load traffic. Small-register runs show the full period of 2^n-1 steps with no earlier repeat.

// File: rtl/prbs_par_gen.sv
module prbs_par_gen #(
  parameter int LEN     = 23,
  parameter int STEP    = 8,
  parameter int TAP_A   = 23,
  parameter int TAP_B   = 18,
  parameter bit REVERSE = 1'b0,
  parameter bit INVERT  = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic            load,
  input  logic [LEN-1:0]  seed,
  output logic [STEP-1:0] dout,
  output logic [LEN-1:0]  state
);

  localparam logic [LEN-1:0] LOCK = INVERT ? {LEN{1'b1}} : {LEN{1'b0}};
  localparam logic [LEN-1:0] SAFE = LOCK ^ {{(LEN-1){1'b0}}, 1'b1};

  logic [LEN-1:0]  adv_s;
  logic [STEP-1:0] adv_b;
  logic            fb;

  always_comb begin
    adv_s = state;
    adv_b = '0;
    fb    = 1'b0;
    for (int i = 0; i < STEP; i++) begin
      fb    = adv_s[TAP_A-1] ^ adv_s[TAP_B-1] ^ INVERT;
      adv_s = {adv_s[LEN-2:0], fb};
      adv_b[REVERSE ? (STEP-1-i) : i] = fb;
    end
  end

  wire [LEN-1:0] seed_ok = (seed == LOCK) ? SAFE : seed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SAFE;
      dout  <= '0;
    end else if (load) begin
      state <= seed_ok;
    end else if (en) begin
      state <= adv_s;
      dout  <= adv_b;
    end
  end

  AST_RESET_VAL: assert property (@(posedge clk) rst |=> (state == SAFE && dout == '0)); // R1
  AST_LOAD_SEED: assert property (@(posedge clk) disable iff (rst)
    (load && seed != LOCK) |=> (state == $past(seed) && $stable(dout))); // R2
  AST_LOAD_LOCK: assert property (@(posedge clk) disable iff (rst)
    (load && seed == LOCK) |=> state == SAFE); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> ($stable(state) && $stable(dout))); // R6
  AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> state != LOCK); // R8

  generate
    if (STEP < LEN) begin : g_shift_chk
      AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> state[LEN-1:STEP] == $past(state[LEN-1-STEP:0])); // R4
    end
    if (STEP <= LEN) begin : g_word_chk
      logic [STEP-1:0] low_in_order;
      always_comb
        for (int k = 0; k < STEP; k++)
          low_in_order[REVERSE ? (STEP-1-k) : k] = state[STEP-1-k];
      AST_WORD_ORDER: assert property (@(posedge clk) disable iff (rst)
        (en && !load) |=> dout == low_in_order); // R5
    end
  endgenerate

endmodule

// File: tb/prbs_par_gen_tb.sv
module prbs_par_gen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;

  logic en_a = 0, load_a = 0; logic [22:0] seed_a = '0;
  logic en_b = 0, load_b = 0; logic [22:0] seed_b = '0;
  logic en_p = 0, load_p = 0; logic [6:0] seed_p = '0; logic [4:0] seed_q = '0;
  logic [7:0] dout_a, dout_b; logic [22:0] st_a, st_b;
  logic dout_p, dout_q; logic [6:0] st_p; logic [4:0] st_q;

  prbs_par_gen u_dut (.clk(clk), .rst(rst), .en(en_a), .load(load_a), .seed(seed_a),
                      .dout(dout_a), .state(st_a));
  prbs_par_gen #(.REVERSE(1'b1), .INVERT(1'b0)) u_rev (.clk(clk), .rst(rst), .en(en_b),
                      .load(load_b), .seed(seed_b), .dout(dout_b), .state(st_b));
  prbs_par_gen #(.LEN(7), .STEP(1), .TAP_A(7), .TAP_B(6)) u_p7 (.clk(clk), .rst(rst),
                      .en(en_p), .load(load_p), .seed(seed_p), .dout(dout_p), .state(st_p));
  prbs_par_gen #(.LEN(5), .STEP(1), .TAP_A(5), .TAP_B(3), .INVERT(1'b0)) u_p5 (.clk(clk),
                      .rst(rst), .en(en_p), .load(load_p), .seed(seed_q), .dout(dout_q), .state(st_q));

  // serial reference: one step of an n-stage register, returns new state; bit 0 is the new bit
  function automatic logic [31:0] ser_step(input logic [31:0] s, input int n, input int ta,
                                           input int tb, input bit inv);
    logic nb;
    nb = s[ta-1] ^ s[tb-1] ^ inv;
    ser_step = ((s << 1) | {31'd0, nb}) & ((32'd1 << n) - 1);
  endfunction

  // model of a 23-bit, 8-bit-step instance
  logic [22:0] m_sa, m_sb; logic [7:0] m_da, m_db;

  task automatic model_cycle(input bit inv, input bit rev, input logic en, input logic ld,
                             input logic [22:0] sd, inout logic [22:0] s, inout logic [7:0] d);
    logic [31:0] t;
    logic [22:0] lk;
    lk = inv ? 23'h7FFFFF : 23'h0;
    if (ld) s = (sd == lk) ? (lk ^ 23'h1) : sd;
    else if (en) begin
      t = {9'd0, s};
      for (int k = 0; k < 8; k++) begin
        t = ser_step(t, 23, 23, 18, inv);
        d[rev ? 7-k : k] = t[0];
      end
      s = t[22:0];
    end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    tick; tick;
    chk("R1 xnor reset state", {9'd0, st_a}, 32'h7FFFFE);
    chk("R1 xor reset state", {9'd0, st_b}, 32'h1);
    chk("R1 reset word", {16'd0, dout_a, dout_b}, 32'h0);
    rst = 0;
    m_sa = 23'h7FFFFE; m_sb = 23'h1; m_da = 0; m_db = 0;

    // R3 lock-up seeds
    load_a = 1; seed_a = 23'h7FFFFF; load_b = 1; seed_b = 23'h0; tick;
    chk("R3 xnor lock seed", {9'd0, st_a}, 32'h7FFFFE);
    chk("R3 xor lock seed", {9'd0, st_b}, 32'h1);

    // R2 load with enable: word holds
    en_a = 1; seed_a = 23'h123456; tick;
    chk("R2 load priority state", {9'd0, st_a}, 32'h123456);
    chk("R2 load keeps word", {24'd0, dout_a}, 32'h0);
    load_a = 0; load_b = 0; en_a = 0;
    m_sa = 23'h123456; m_sb = 23'h1;

    // R4 R5 R9 directed steps
    en_a = 1; en_b = 1;
    model_cycle(1, 0, 1, 0, 0, m_sa, m_da); model_cycle(0, 1, 1, 0, 0, m_sb, m_db);
    tick;
    chk("R4 R9 xnor step state", {9'd0, st_a}, {9'd0, m_sa});
    chk("R5 normal order word", {24'd0, dout_a}, {24'd0, m_da});
    chk("R4 R9 xor step state", {9'd0, st_b}, {9'd0, m_sb});
    chk("R5 reverse order word", {24'd0, dout_b}, {24'd0, m_db});

    // R6 idle hold
    en_a = 0; en_b = 0; seed_a = 23'h55555; tick; tick;
    chk("R6 hold state", {9'd0, st_a}, {9'd0, m_sa});
    chk("R6 hold word", {16'd0, dout_a, dout_b}, {16'd0, m_da, m_db});

    // random traffic against the model
    for (int c = 0; c < 600; c++) begin
      en_a = ($urandom_range(0, 3) != 0); load_a = ($urandom_range(0, 15) == 0);
      seed_a = ($urandom_range(0, 3) == 0) ? 23'h7FFFFF : 23'($urandom);
      en_b = ($urandom_range(0, 3) != 0); load_b = ($urandom_range(0, 15) == 0);
      seed_b = ($urandom_range(0, 3) == 0) ? 23'h0 : 23'($urandom);
      model_cycle(1, 0, en_a, load_a, seed_a, m_sa, m_da);
      model_cycle(0, 1, en_b, load_b, seed_b, m_sb, m_db);
      tick;
      chk("R2 R4 R5 R6 R9 random xnor", {1'b0, st_a, dout_a}, {1'b0, m_sa, m_da});
      chk("R2 R4 R5 R6 R9 random xor rev", {1'b0, st_b, dout_b}, {1'b0, m_sb, m_db});
      chk("R8 no lockup", {31'd0, (st_a == 23'h7FFFFF) || (st_b == 23'h0)}, 32'd0);
    end
    en_a = 0; load_a = 0; en_b = 0; load_b = 0;

    // R7 period on small registers
    begin
      int early7, early5;
      logic [31:0] r7;
      early7 = 0; early5 = 0;
      load_p = 1; seed_p = 7'h15; seed_q = 5'h09; tick; load_p = 0;
      chk("R2 small seed", {20'd0, st_p, st_q}, {20'd0, 7'h15, 5'h09});
      r7 = 32'h15; en_p = 1;
      for (int i = 1; i <= 127; i++) begin
        tick;
        r7 = ser_step(r7, 7, 7, 6, 1);
        if (i == 1) chk("R4 serial bit", {31'd0, dout_p}, {31'd0, r7[0]});
        if (i < 127 && st_p == 7'h15) early7++;
        if (i < 31 && st_q == 5'h09) early5++;
        if (i == 31) chk("R7 R9 xor period 31", {27'd0, st_q}, 32'h09);
      end
      en_p = 0;
      chk("R7 xnor period 127", {25'd0, st_p}, 32'h15);
      chk("R7 no early repeat", early7 + early5, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule